// File: doc/BRIEF.md
# Configurable UART Frame Receiver

This block turns an asynchronous serial line into parallel words. An external prescaler supplies a sample tick that pulses `OSR` times per bit period. The receiver waits for a falling edge on the synchronized line and confirms the start bit at its middle. It then takes one sample per bit at mid-bit: the data bits, an optional parity bit, and one or two stop bits.

The word length can be set from 6 to 13 bits. Bits can arrive least-significant first or most-significant first. Parity can be off, odd, even or stick. Every finished frame produces a 16-bit result with a single-cycle valid strobe. The data sits right-aligned in the low bits, and the three status bits of that frame sit at the top. The result also updates three sticky line-status flags. Two event flags mark the start and the end of each reception, and a busy output shows that a frame is in progress.

The whole configuration is captured at the falling edge that opens a frame. A frame is therefore always finished in the format it started with.

Top module: `uart_frame_rx`

## Requirements
- R1: The 4-bit length code `wlen_i` selects the number of data bits. Codes 6 to 13 give that many bits, codes below 6 (including 0) give 6, and codes 14 and 15 give 13. The data lands right-aligned in `word_o[12:0]`, and unused data bits read 0.
- R2: With `lsb_first_i`=1 the first data bit received is stored in bit 0. With `lsb_first_i`=0 the first data bit is stored in bit N-1, where N is the selected length.
- R3: With `par_en_i`=1 a parity bit follows the data. In even mode (`par_even_i`=1) the data plus parity must hold an even number of ones, and in odd mode an odd number. A mismatch sets `word_o[13]`. With parity off, `word_o[13]` is 0 and the stop bit follows the last data bit.
- R4: With `par_stick_i`=1 (and parity on), the expected parity bit is the inverse of `par_even_i`, whatever the data.
- R5: If the first stop bit is sampled as 0, `word_o[14]` is set. When two stop bits are selected (`stop2_i`=1), the second is sampled but never causes a framing error.
- R6: If every bit sampled from the start bit through the last stop bit is 0, `word_o[15]` (break) is set, together with `word_o[14]`. No new frame begins until the line has gone high and then fallen again.
- R7: `rx_inv_i` inverts the raw line before the synchronizer. A frame starts on a falling edge of the synchronized line. If the line is high at the middle of the start bit, the receiver returns to idle: no word, no start event.
- R8: The result is `{break, framing, parity, data[12:0]}`. `word_valid_o` is high for exactly one cycle per finished frame, and `word_o` holds its value until the next frame finishes. After reset both are 0.
- R9: `busy_o` is high from the detected falling edge until the last stop bit is sampled. It is low in idle and in the cycle in which `word_valid_o` is high.
- R10: `start_flag_o` is set when a start bit is confirmed, and `end_flag_o` is set when a word is delivered. Each stays set until its clear input (`clr_start_i`, `clr_end_i`) is pulsed.
- R11: `brk_flag_o`, `fe_flag_o` and `pe_flag_o` are set from the status bits of each delivered word and stay set. One pulse of `clr_line_i` clears all three together.
- R12: The start bit is sampled on the `OSR/2`-th tick after the falling edge, and each later bit every `OSR` ticks. The receiver does nothing between ticks. Configuration changes made during a frame have no effect on that frame.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| rx_i | input | 1 | Raw serial line |
| rx_inv_i | input | 1 | Invert the raw line before synchronization |
| tick_i | input | 1 | Sample tick, OSR pulses per bit period |
| wlen_i | input | 4 | Data length code |
| lsb_first_i | input | 1 | 1: least-significant bit first |
| par_en_i | input | 1 | Parity bit present |
| par_even_i | input | 1 | Even parity select |
| par_stick_i | input | 1 | Stick parity select |
| stop2_i | input | 1 | Two stop bits |
| clr_start_i | input | 1 | Clear the start event flag |
| clr_end_i | input | 1 | Clear the end event flag |
| clr_line_i | input | 1 | Clear all three line-status flags |
| word_o | output | 16 | Received word with status in bits 15:13 |
| word_valid_o | output | 1 | One-cycle strobe for a new word |
| busy_o | output | 1 | Frame in progress |
| start_flag_o | output | 1 | Start event flag |
| end_flag_o | output | 1 | End event flag |
| pe_flag_o | output | 1 | Sticky parity error flag |
| fe_flag_o | output | 1 | Sticky framing error flag |
| brk_flag_o | output | 1 | Sticky break flag |

## Verification
The embedded properties assume three things about the inputs. Reset is asserted from time zero. `tick_i` is a single-cycle pulse. No frame is shorter than a few clock cycles, so two valid strobes can never be adjacent.

The stimulus keeps within these assumptions:
- It holds every line level for a whole number of tick periods.
- It changes the inversion select in the same cycle as the raw level, so no spurious edge appears on the synchronized line.
- It flips the length code and the bit order in the middle of a frame, to show that the captured configuration governs that frame.

// File: rtl/uart_rx_pkg.sv
package uart_rx_pkg;

    localparam int DATA_W   = 13;
    localparam int WORD_W   = 16;
    localparam int MIN_BITS = 6;
    localparam int MAX_BITS = 13;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_START,
        ST_DATA,
        ST_PARITY,
        ST_STOP1,
        ST_STOP2
    } rx_state_e;

    typedef struct packed {
        logic [3:0] nbits;
        logic       lsb_first;
        logic       par_en;
        logic       par_even;
        logic       par_stick;
        logic       stop2;
    } rx_cfg_t;

    typedef struct packed {
        logic              brk;
        logic              fe;
        logic              pe;
        logic [DATA_W-1:0] data;
    } rx_word_t;

    // Map a length code onto the supported data-bit range.
    function automatic logic [3:0] nbits_of(input logic [3:0] code);
        if (code < 4'(MIN_BITS))
            return 4'(MIN_BITS);
        else if (code > 4'(MAX_BITS))
            return 4'(MAX_BITS);
        else
            return code;
    endfunction

    // Parity bit the sender should have placed after the data.
    function automatic logic parity_expect(input logic acc, input logic even, input logic stick);
        if (stick)
            return ~even;
        else if (even)
            return acc;
        else
            return ~acc;
    endfunction

endpackage

// File: rtl/rx_line_front.sv
module rx_line_front #(
    parameter int SYNC_N = 2
) (
    input  logic clk,
    input  logic rst,
    input  logic rx_i,
    input  logic inv_i,
    output logic line_o,
    output logic fall_o
);

    logic [SYNC_N:0] pipe;

    always_ff @(posedge clk) begin
        if (rst)
            pipe <= '1;
        else
            pipe <= {pipe[SYNC_N-1:0], rx_i ^ inv_i};
    end

    assign line_o = pipe[SYNC_N-1];
    assign fall_o = pipe[SYNC_N] & ~pipe[SYNC_N-1];

endmodule

// File: rtl/rx_frame_engine.sv
module rx_frame_engine
    import uart_rx_pkg::*;
#(
    parameter int OSR = 8
) (
    input  logic                clk,
    input  logic                rst,
    input  logic                tick_i,
    input  logic                line_i,
    input  logic                fall_i,
    input  rx_cfg_t             cfg_i,
    output logic                busy_o,
    output logic                start_evt_o,
    output logic [WORD_W-1:0]   word_o,
    output logic                word_valid_o
);

    localparam int CW = (OSR > 2) ? $clog2(OSR) : 1;
    localparam logic [CW-1:0] HALF_M1 = CW'(OSR / 2 - 1);
    localparam logic [CW-1:0] FULL_M1 = CW'(OSR - 1);

    rx_state_e          st;
    rx_cfg_t            cfg_q;
    logic [CW-1:0]      tcnt;
    logic [3:0]         bidx;
    logic [3:0]         pos;
    logic [DATA_W-1:0]  shreg;
    logic               par_acc;
    logic               all_zero;
    logic               pe_q;
    logic               fe_q;
    logic               at_mid;
    logic               az_now;
    logic               fe_now;
    logic               finish;
    rx_word_t           word_q;
    logic               valid_q;
    logic               start_q;

    assign at_mid = tick_i && (tcnt == ((st == ST_START) ? HALF_M1 : FULL_M1));
    assign pos    = cfg_q.lsb_first ? bidx : (cfg_q.nbits - 4'd1 - bidx);
    assign az_now = all_zero & ~line_i;
    assign fe_now = (st == ST_STOP1) ? ~line_i : fe_q;
    assign finish = at_mid && ((st == ST_STOP2) || (st == ST_STOP1 && !cfg_q.stop2));

    always_ff @(posedge clk) begin
        if (rst) begin
            st       <= ST_IDLE;
            cfg_q    <= '0;
            tcnt     <= '0;
            bidx     <= '0;
            shreg    <= '0;
            par_acc  <= 1'b0;
            all_zero <= 1'b1;
            pe_q     <= 1'b0;
            fe_q     <= 1'b0;
            word_q   <= '0;
            valid_q  <= 1'b0;
            start_q  <= 1'b0;
        end else begin
            valid_q <= 1'b0;
            start_q <= 1'b0;
            if (tick_i && st != ST_IDLE)
                tcnt <= at_mid ? '0 : tcnt + 1'b1;
            unique case (st)
                ST_IDLE: begin
                    if (fall_i) begin
                        st       <= ST_START;
                        tcnt     <= '0;
                        cfg_q    <= cfg_i;
                        bidx     <= '0;
                        shreg    <= '0;
                        par_acc  <= 1'b0;
                        all_zero <= 1'b1;
                        pe_q     <= 1'b0;
                        fe_q     <= 1'b0;
                    end
                end
                ST_START: begin
                    if (at_mid) begin
                        if (!line_i) begin
                            st      <= ST_DATA;
                            start_q <= 1'b1;
                        end else begin
                            st <= ST_IDLE;
                        end
                    end
                end
                ST_DATA: begin
                    if (at_mid) begin
                        shreg[pos] <= line_i;
                        par_acc    <= par_acc ^ line_i;
                        all_zero   <= az_now;
                        bidx       <= bidx + 4'd1;
                        if (bidx == cfg_q.nbits - 4'd1)
                            st <= cfg_q.par_en ? ST_PARITY : ST_STOP1;
                    end
                end
                ST_PARITY: begin
                    if (at_mid) begin
                        pe_q     <= line_i != parity_expect(par_acc, cfg_q.par_even, cfg_q.par_stick);
                        all_zero <= az_now;
                        st       <= ST_STOP1;
                    end
                end
                ST_STOP1: begin
                    if (at_mid) begin
                        fe_q     <= ~line_i;
                        all_zero <= az_now;
                        if (cfg_q.stop2)
                            st <= ST_STOP2;
                    end
                end
                ST_STOP2: begin
                    if (at_mid)
                        all_zero <= az_now;
                end
                default: st <= ST_IDLE;
            endcase
            if (finish) begin
                st          <= ST_IDLE;
                word_q.brk  <= az_now;
                word_q.fe   <= fe_now;
                word_q.pe   <= pe_q;
                word_q.data <= shreg;
                valid_q     <= 1'b1;
            end
        end
    end

    assign busy_o       = (st != ST_IDLE);
    assign start_evt_o  = start_q;
    assign word_o       = word_q;
    assign word_valid_o = valid_q;

    a_r1_index_in_range: assert property (@(posedge clk) disable iff (rst)
        (st == ST_DATA) |-> (bidx < cfg_q.nbits));
    a_r3_no_parity_no_error: assert property (@(posedge clk) disable iff (rst)
        (word_valid_o && !cfg_q.par_en) |-> !word_o[13]);
    a_r6_break_implies_framing: assert property (@(posedge clk) disable iff (rst)
        (word_valid_o && word_o[15]) |-> word_o[14]);
    a_r8_valid_single_cycle: assert property (@(posedge clk) disable iff (rst)
        word_valid_o |=> !word_valid_o);
    a_r9_idle_at_delivery: assert property (@(posedge clk) disable iff (rst)
        word_valid_o |-> !busy_o);

endmodule

// File: rtl/rx_status_flags.sv
module rx_status_flags (
    input  logic       clk,
    input  logic       rst,
    input  logic       valid_i,
    input  logic [2:0] status_i,
    input  logic       start_evt_i,
    input  logic       clr_start_i,
    input  logic       clr_end_i,
    input  logic       clr_line_i,
    output logic       start_flag_o,
    output logic       end_flag_o,
    output logic       brk_flag_o,
    output logic       fe_flag_o,
    output logic       pe_flag_o
);

    logic [2:0] line_q;
    logic       start_q;
    logic       end_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            line_q  <= '0;
            start_q <= 1'b0;
            end_q   <= 1'b0;
        end else begin
            line_q  <= (line_q & {3{~clr_line_i}}) | (status_i & {3{valid_i}});
            start_q <= (start_q & ~clr_start_i) | start_evt_i;
            end_q   <= (end_q & ~clr_end_i) | valid_i;
        end
    end

    assign brk_flag_o   = line_q[2];
    assign fe_flag_o    = line_q[1];
    assign pe_flag_o    = line_q[0];
    assign start_flag_o = start_q;
    assign end_flag_o   = end_q;

    a_r10_start_clear: assert property (@(posedge clk) disable iff (rst)
        (clr_start_i && !start_evt_i) |=> !start_flag_o);
    a_r10_end_on_word: assert property (@(posedge clk) disable iff (rst)
        valid_i |=> end_flag_o);
    a_r11_break_sticks: assert property (@(posedge clk) disable iff (rst)
        (valid_i && status_i[2]) |=> brk_flag_o);
    a_r11_clear_all: assert property (@(posedge clk) disable iff (rst)
        (clr_line_i && !valid_i) |=> (!brk_flag_o && !fe_flag_o && !pe_flag_o));

endmodule

// File: rtl/uart_frame_rx.sv
module uart_frame_rx
    import uart_rx_pkg::*;
#(
    parameter int OSR    = 8,
    parameter int SYNC_N = 2
) (
    input  logic        clk,
    input  logic        rst,
    input  logic        rx_i,
    input  logic        rx_inv_i,
    input  logic        tick_i,
    input  logic [3:0]  wlen_i,
    input  logic        lsb_first_i,
    input  logic        par_en_i,
    input  logic        par_even_i,
    input  logic        par_stick_i,
    input  logic        stop2_i,
    input  logic        clr_start_i,
    input  logic        clr_end_i,
    input  logic        clr_line_i,
    output logic [15:0] word_o,
    output logic        word_valid_o,
    output logic        busy_o,
    output logic        start_flag_o,
    output logic        end_flag_o,
    output logic        pe_flag_o,
    output logic        fe_flag_o,
    output logic        brk_flag_o
);

    logic    line;
    logic    fall;
    logic    start_evt;
    rx_cfg_t cfg;

    always_comb begin
        cfg.nbits     = nbits_of(wlen_i);
        cfg.lsb_first = lsb_first_i;
        cfg.par_en    = par_en_i;
        cfg.par_even  = par_even_i;
        cfg.par_stick = par_stick_i;
        cfg.stop2     = stop2_i;
    end

    rx_line_front #(.SYNC_N(SYNC_N)) u_front (
        .clk    (clk),
        .rst    (rst),
        .rx_i   (rx_i),
        .inv_i  (rx_inv_i),
        .line_o (line),
        .fall_o (fall)
    );

    rx_frame_engine #(.OSR(OSR)) u_engine (
        .clk          (clk),
        .rst          (rst),
        .tick_i       (tick_i),
        .line_i       (line),
        .fall_i       (fall),
        .cfg_i        (cfg),
        .busy_o       (busy_o),
        .start_evt_o  (start_evt),
        .word_o       (word_o),
        .word_valid_o (word_valid_o)
    );

    rx_status_flags u_flags (
        .clk          (clk),
        .rst          (rst),
        .valid_i      (word_valid_o),
        .status_i     (word_o[15:13]),
        .start_evt_i  (start_evt),
        .clr_start_i  (clr_start_i),
        .clr_end_i    (clr_end_i),
        .clr_line_i   (clr_line_i),
        .start_flag_o (start_flag_o),
        .end_flag_o   (end_flag_o),
        .brk_flag_o   (brk_flag_o),
        .fe_flag_o    (fe_flag_o),
        .pe_flag_o    (pe_flag_o)
    );

endmodule

// File: tb/uart_frame_rx_bench.sv
`timescale 1ns/1ps
module uart_frame_rx_bench;

    localparam int OSR = 8;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        rx = 1'b1, inv = 1'b0, tick = 1'b0;
    logic [3:0]  wlen = 4'd8;
    logic        lsb = 1'b1, pen = 1'b0, peven = 1'b0, pstick = 1'b0, two = 1'b0;
    logic        clr_s = 1'b0, clr_e = 1'b0, clr_l = 1'b0;
    logic [15:0] word;
    logic        wvalid, busy, sflag, eflag, peflag, feflag, brkflag;

    int          n_chk = 0;
    int          n_fail = 0;
    int          tdiv = 2;
    int          tphase = 0;
    logic [15:0] exp_q[$];
    string       tag_q[$];

    always #2.5 clk = ~clk;

    uart_frame_rx #(.OSR(OSR)) u_uart_frame_rx (
        .clk(clk), .rst(rst), .rx_i(rx), .rx_inv_i(inv), .tick_i(tick),
        .wlen_i(wlen), .lsb_first_i(lsb), .par_en_i(pen), .par_even_i(peven),
        .par_stick_i(pstick), .stop2_i(two), .clr_start_i(clr_s), .clr_end_i(clr_e),
        .clr_line_i(clr_l), .word_o(word), .word_valid_o(wvalid), .busy_o(busy),
        .start_flag_o(sflag), .end_flag_o(eflag), .pe_flag_o(peflag),
        .fe_flag_o(feflag), .brk_flag_o(brkflag)
    );

    // Tick generator: one pulse every tdiv cycles.
    initial begin
        forever begin
            @(negedge clk);
            tphase = tphase + 1;
            tick = (tphase % tdiv) == 0;
        end
    end

    task automatic chk(input string tag, input logic [15:0] act, input logic [15:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    // Monitor: compare every delivered word with the scoreboard head.
    always @(negedge clk) begin
        if (!rst && wvalid) begin
            if (exp_q.size() == 0) begin
                n_chk++;
                n_fail++;
                $display("FAIL R8 unexpected word actual=%h expected=none", word);
            end else begin
                chk(tag_q.pop_front(), word, exp_q.pop_front());
            end
        end
    end

    task automatic line_bit(input logic v);
        rx = v ^ inv;
        repeat (OSR * tdiv) @(negedge clk);
    endtask

    task automatic drain(input string tag);
        repeat (4) @(negedge clk);
        n_chk++;
        if (exp_q.size() != 0) begin
            n_fail++;
            $display("FAIL %s missing word actual=none expected=%h", tag, exp_q[0]);
            exp_q.delete();
            tag_q.delete();
        end
    endtask

    // Driver: builds one frame from the current configuration, pushes the expected word.
    task automatic send_frame(input string tag, input logic [12:0] d, input logic bad_par,
                              input logic bad_stop, input logic stop2v, input logic chg);
        int          n;
        logic [12:0] dm;
        logic        pbit;
        logic [3:0]  sv_wlen;
        logic        sv_lsb;
        logic        sv_pen, sv_two;
        n  = (wlen < 4'd6) ? 6 : (wlen > 4'd13) ? 13 : int'(wlen);
        dm = d & 13'((1 << n) - 1);
        pbit = pstick ? ~peven : (peven ? ^dm : ~^dm);
        if (bad_par) pbit = ~pbit;
        sv_wlen = wlen; sv_lsb = lsb; sv_pen = pen; sv_two = two;
        exp_q.push_back({1'b0, bad_stop, pen & bad_par, dm});
        tag_q.push_back(tag);
        line_bit(1'b0);
        if (chg) begin
            wlen = (wlen == 4'd13) ? 4'd6 : 4'd13;
            lsb  = ~lsb;
        end
        for (int i = 0; i < n; i++)
            line_bit(sv_lsb ? dm[i] : dm[n-1-i]);
        if (sv_pen) line_bit(pbit);
        line_bit(~bad_stop);
        if (sv_two) line_bit(stop2v);
        wlen = sv_wlen; lsb = sv_lsb;
        line_bit(1'b1);
        line_bit(1'b1);
        drain(tag);
    endtask

    task automatic pulse(input int which);
        @(negedge clk);
        if (which == 0) clr_s = 1'b1;
        else if (which == 1) clr_e = 1'b1;
        else clr_l = 1'b1;
        @(negedge clk);
        clr_s = 1'b0; clr_e = 1'b0; clr_l = 1'b0;
    endtask

    initial begin
        repeat (5) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        // R8, R9, R10, R11: reset state
        chk("R8 reset word", word, 16'h0000);
        chk("R9 reset status", {9'd0, wvalid, busy, sflag, eflag, peflag, feflag, brkflag}, 16'h0000);

        // R1, R2: 8 bits, LSB first; R9 busy during frame
        fork
            send_frame("R2 lsb-first 8 bit", 13'h0A5, 1'b0, 1'b0, 1'b1, 1'b0);
            begin
                repeat (5 * OSR * tdiv) @(negedge clk);
                chk("R9 busy mid-frame", {15'd0, busy}, 16'h0001);
            end
        join
        chk("R9 busy after frame", {15'd0, busy}, 16'h0000);
        chk("R10 flags set", {14'd0, sflag, eflag}, 16'h0003);
        pulse(0);
        chk("R10 start cleared", {14'd0, sflag, eflag}, 16'h0001);
        pulse(1);
        chk("R10 end cleared", {14'd0, sflag, eflag}, 16'h0000);

        // R2: MSB first
        lsb = 1'b0;
        send_frame("R2 msb-first 8 bit", 13'h01C, 1'b0, 1'b0, 1'b1, 1'b0);
        // R1: 13 bits MSB first, and clamp codes
        wlen = 4'd13;
        send_frame("R1 13 bit msb", 13'h1ABC, 1'b0, 1'b0, 1'b1, 1'b0);
        lsb = 1'b1; wlen = 4'd0;
        send_frame("R1 code 0 gives 6 bits", 13'h1FED, 1'b0, 1'b0, 1'b1, 1'b0);
        wlen = 4'd15;
        send_frame("R1 code 15 gives 13 bits", 13'h1357, 1'b0, 1'b0, 1'b1, 1'b0);
        wlen = 4'd7;
        send_frame("R1 7 bit", 13'h05A, 1'b0, 1'b0, 1'b1, 1'b0);

        // R3: parity
        wlen = 4'd8; pen = 1'b1; peven = 1'b1;
        send_frame("R3 even good", 13'h0B7, 1'b0, 1'b0, 1'b1, 1'b0);
        send_frame("R3 even bad", 13'h0B7, 1'b1, 1'b0, 1'b1, 1'b0);
        peven = 1'b0;
        send_frame("R3 odd good", 13'h031, 1'b0, 1'b0, 1'b1, 1'b0);
        chk("R11 no pe set yet cleared check", {15'd0, peflag}, 16'h0001);
        pulse(2);
        chk("R11 clear line flags", {13'd0, brkflag, feflag, peflag}, 16'h0000);
        send_frame("R3 odd bad", 13'h031, 1'b1, 1'b0, 1'b1, 1'b0);
        chk("R11 pe flag sticky", {15'd0, peflag}, 16'h0001);

        // R4: stick parity
        pstick = 1'b1; peven = 1'b1;
        send_frame("R4 stick even expects 0", 13'h007, 1'b0, 1'b0, 1'b1, 1'b0);
        send_frame("R4 stick even bad", 13'h006, 1'b1, 1'b0, 1'b1, 1'b0);
        peven = 1'b0;
        send_frame("R4 stick odd expects 1", 13'h006, 1'b0, 1'b0, 1'b1, 1'b0);
        pstick = 1'b0; pen = 1'b0;

        // R5: framing
        send_frame("R5 stop low", 13'h0C3, 1'b0, 1'b1, 1'b1, 1'b0);
        chk("R11 fe flag", {15'd0, feflag}, 16'h0001);
        two = 1'b1;
        send_frame("R5 second stop unchecked", 13'h03C, 1'b0, 1'b0, 1'b0, 1'b0);
        send_frame("R5 two stops good", 13'h0E1, 1'b0, 1'b0, 1'b1, 1'b0);
        two = 1'b0;

        // R6: break (8 bits, no parity, one stop)
        exp_q.push_back(16'hC000);
        tag_q.push_back("R6 break word");
        rx = 1'b0;
        repeat (12 * OSR * tdiv) @(negedge clk);
        rx = 1'b1;
        repeat (2 * OSR * tdiv) @(negedge clk);
        drain("R6 break word");
        chk("R11 brk and fe flags", {14'd0, brkflag, feflag}, 16'h0003);
        pulse(2);
        chk("R11 all cleared", {13'd0, brkflag, feflag, peflag}, 16'h0000);

        // R7: glitch rejected
        pulse(0);
        rx = 1'b0;
        repeat (tdiv * 2) @(negedge clk);
        rx = 1'b1;
        repeat (3 * OSR * tdiv) @(negedge clk);
        chk("R7 glitch no start", {14'd0, sflag, busy}, 16'h0000);
        // R7: inverted line
        rx = 1'b0; inv = 1'b1;
        repeat (4) @(negedge clk);
        send_frame("R7 inverted line", 13'h096, 1'b0, 1'b0, 1'b1, 1'b0);
        rx = 1'b1; inv = 1'b0;
        repeat (4) @(negedge clk);

        // R12: slower tick and mid-frame config change
        tdiv = 4;
        wlen = 4'd9;
        send_frame("R12 slow tick 9 bit", 13'h1A5, 1'b0, 1'b0, 1'b1, 1'b0);
        tdiv = 2;
        wlen = 4'd8;
        send_frame("R12 config captured at start", 13'h0D2, 1'b0, 1'b0, 1'b1, 1'b1);

        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        n_chk++;
        n_fail++;
        $display("FAIL watchdog expired actual=running expected=finished");
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end

endmodule